// File: doc/BRIEF.md
# Plane Trigger Proposal Logic

This block collects eighteen hit lines from the channel discriminators and forms two trigger proposals. Channels 0 to 8 form the induction proposal and channels 9 to 17 form the collection proposal. Each hit line is first brought into the 10 MHz logic clock by a two-stage synchronizer and then reduced to a one-clock pulse on its rising edge. A proposal fires when any unmasked pulse of its plane arrives. The proposal output then stays high for a programmed number of clocks and cannot be restarted while it is high.

Alongside the proposals, every channel has a saturating hit counter. The counter is sampled and cleared at the end of each fixed gate of clocks, so software reads hits per gate. In test mode a pattern register replaces the physical hit lines ahead of the synchronizer. One chosen channel's synchronized level is copied to a monitor pin. An 8-bit threshold value for each channel is held here and driven out to the DAC logic.

All settings are reached through a flat register port: address, write strobe, write data and combinational read data. A serial command decoder upstream drives this port.

Top module: `ltrig_ctrl`

## Requirements
- R1: A rising edge on a channel in 0..8 raises `trig_ind_o`, and a rising edge on a channel in 9..17 raises `trig_col_o`. Neither plane's channels affect the other output.
- R2: A channel whose bit in the block register (address 0x00, bit i = channel i, 1 = blocked) is set never starts a proposal. The register reads back the written value.
- R3: A hit-line rise that is set up before clock edge 1 makes the proposal output high after clock edge 3. Each rise gives exactly one internal pulse, even if the line stays high.
- R4: A proposal stays high for exactly W clocks, where W is the 8-bit value at address 0x03. W = 0 behaves as 1. The reset value is 1.
- R5: An edge that arrives while a proposal is high is dropped. It neither lengthens the proposal nor starts a new one afterwards.
- R6: Per-channel hit counts cover consecutive gates of GATE_CLKS clocks. The result of the last complete gate reads at address 0x40+i. Blocking a channel does not stop its count.
- R7: A count that reaches all ones (2^CNT_W − 1) stays there until the gate ends and does not wrap.
- R8: When bit 0 at address 0x02 is 1, the channel sources come from the pattern register (address 0x01, bit i = channel i). The physical hit inputs are then ignored.
- R9: The monitor output follows the synchronized level of the channel selected by the 5-bit value at address 0x04, with the same latency as R3. Selector values 18..31 hold the monitor low.
- R10: The 8-bit threshold of channel i is written and read at address 0x20+i. It appears on `thr_o[8*i+7:8*i]` after the write clock.
- R11: After reset both proposals and the monitor are low. The block register, pattern, test bit, monitor selector and thresholds are 0, and the width is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock (10 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disc_i | input | 18 | Discriminated hit lines, one per channel |
| bus_addr | input | 7 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 18 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| trig_ind_o | output | 1 | Induction-plane trigger proposal |
| trig_col_o | output | 1 | Collection-plane trigger proposal |
| mon_o | output | 1 | Monitor copy of the selected channel |
| thr_o | output | 144 | Eight-bit thresholds, channel i in bits 8i+7..8i |

## Verification
A broken synchronizer or edge detector appears as a proposal that rises one clock early or late, or as a proposal that restarts while a line is held high. Either shows on the output pins within four clocks of the stimulus. A wrong stretch counter shows as a high time different from W, or as a second proposal after a dropped edge. Both are visible within W plus a few clocks. A miscounting or wrapping rate counter, or a gate that does not clear, appears in the rate readout only after one or two full gates. For that reason the bench uses a short gate and periodic stimulus whose edge count per gate does not depend on phase.

// File: rtl/ltrig_pkg.sv
package ltrig_pkg;
  localparam int ADDR_W = 7;
  localparam int RD_W   = 32;
  localparam int THR_W  = 8;
  localparam int WID_W  = 8;
  localparam int SEL_W  = 5;

  localparam logic [ADDR_W-1:0] A_BLOCK    = 7'h00;
  localparam logic [ADDR_W-1:0] A_PATTERN  = 7'h01;
  localparam logic [ADDR_W-1:0] A_TESTEN   = 7'h02;
  localparam logic [ADDR_W-1:0] A_WIDTH    = 7'h03;
  localparam logic [ADDR_W-1:0] A_MONSEL   = 7'h04;
  localparam logic [ADDR_W-1:0] A_THR_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 7'h40;
endpackage

// File: rtl/ltrig_hitfront.sv
module ltrig_hitfront #(
  parameter int NCH = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] src,
  output logic [NCH-1:0] lvl,
  output logic [NCH-1:0] pulse
);
  logic [NCH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= src;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl   = s2_q;
  assign pulse = s2_q & ~s3_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R3: a pulse lasts a single clock
    p_one_clock_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[g] |=> !pulse[g]);
  end
endmodule

// File: rtl/ltrig_stretch.sv
module ltrig_stretch #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [WID_W-1:0] width,
  output logic             busy
);
  logic [WID_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else if (trig)
      cnt_d = (width == '0) ? WID_W'(1) : width;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R1: the output only starts after a plane hit
  p_start_on_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig));
  // R5: no early end while counting
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != WID_W'(1)) |=> busy);
  // R4: the last count ends the output
  p_end_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == WID_W'(1)) |=> !busy);
endmodule

// File: rtl/ltrig_ratemeter.sv
module ltrig_ratemeter #(
  parameter int NCH       = 18,
  parameter int GATE_CLKS = 10_000_000,
  parameter int CNT_W     = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       pulse,
  output logic [NCH*CNT_W-1:0] rate_flat
);
  localparam int GATE_W = (GATE_CLKS > 2) ? $clog2(GATE_CLKS) : 1;
  localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_CLKS - 1);
  localparam logic [CNT_W-1:0]  CMAX = '1;

  logic [GATE_W-1:0] gate_q, gate_d;
  logic              gate_end;

  assign gate_end = (gate_q == GATE_LAST);
  assign gate_d   = gate_end ? '0 : gate_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] cnt_q, cnt_d, rate_q, rate_d, inc;

    always_comb begin
      inc    = (pulse[g] && cnt_q != CMAX) ? cnt_q + 1'b1 : cnt_q;
      cnt_d  = gate_end ? '0 : inc;
      rate_d = gate_end ? inc : rate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        rate_q <= '0;
      end else begin
        cnt_q  <= cnt_d;
        rate_q <= rate_d;
      end
    end

    assign rate_flat[g*CNT_W +: CNT_W] = rate_q;

    // R7: a full counter holds within the gate
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CMAX && !gate_end) |=> cnt_q == CMAX);
    // R6: a gate boundary clears the running count
    p_gate_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> cnt_q == '0);
  end
endmodule

// File: rtl/ltrig_regs.sv
module ltrig_regs
  import ltrig_pkg::*;
#(
  parameter int NCH   = 18,
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [NCH-1:0]       wdata,
  output logic [RD_W-1:0]      rdata,
  input  logic [NCH*CNT_W-1:0] rate_flat,
  output logic [NCH-1:0]       block,
  output logic [NCH-1:0]       pattern,
  output logic                 test_en,
  output logic [WID_W-1:0]     width,
  output logic [SEL_W-1:0]     mon_sel,
  output logic [NCH*THR_W-1:0] thr_flat
);
  logic [NCH-1:0]   block_d, pattern_d;
  logic             test_d;
  logic [WID_W-1:0] width_d;
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    block_d   = block;
    pattern_d = pattern;
    test_d    = test_en;
    width_d   = width;
    sel_d     = mon_sel;
    if (we) begin
      case (addr)
        A_BLOCK:   block_d   = wdata;
        A_PATTERN: pattern_d = wdata;
        A_TESTEN:  test_d    = wdata[0];
        A_WIDTH:   width_d   = wdata[WID_W-1:0];
        A_MONSEL:  sel_d     = wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block   <= '0;
      pattern <= '0;
      test_en <= 1'b0;
      width   <= WID_W'(1);
      mon_sel <= '0;
    end else begin
      block   <= block_d;
      pattern <= pattern_d;
      test_en <= test_d;
      width   <= width_d;
      mon_sel <= sel_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_thr
    logic [THR_W-1:0] thr_q;
    logic             thr_hit;
    assign thr_hit = we && (addr == A_THR_BASE + ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       thr_q <= '0;
      else if (thr_hit) thr_q <= wdata[THR_W-1:0];
    end
    assign thr_flat[g*THR_W +: THR_W] = thr_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_BLOCK:   rdata = RD_W'(block);
      A_PATTERN: rdata = RD_W'(pattern);
      A_TESTEN:  rdata = RD_W'(test_en);
      A_WIDTH:   rdata = RD_W'(width);
      A_MONSEL:  rdata = RD_W'(mon_sel);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr == A_THR_BASE + ADDR_W'(i)) rdata = RD_W'(thr_flat[i*THR_W +: THR_W]);
      if (addr == A_CNT_BASE + ADDR_W'(i)) rdata = RD_W'(rate_flat[i*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/ltrig_ctrl.sv
module ltrig_ctrl
  import ltrig_pkg::*;
#(
  parameter int NCH       = 18,
  parameter int NIND      = 9,
  parameter int GATE_CLKS = 10_000_000,
  parameter int CNT_W     = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       disc_i,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [NCH-1:0]       bus_wdata,
  output logic [RD_W-1:0]      bus_rdata,
  output logic                 trig_ind_o,
  output logic                 trig_col_o,
  output logic                 mon_o,
  output logic [NCH*THR_W-1:0] thr_o
);
  logic rs1_q, rs2_q, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  logic [NCH-1:0]       block, pattern, src, lvl, pulse, live;
  logic                 test_en;
  logic [WID_W-1:0]     width;
  logic [SEL_W-1:0]     mon_sel;
  logic [NCH*CNT_W-1:0] rate_flat;
  logic                 hit_ind, hit_col, mon_d;

  ltrig_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .rate_flat(rate_flat), .block(block), .pattern(pattern),
    .test_en(test_en), .width(width), .mon_sel(mon_sel), .thr_flat(thr_o)
  );

  assign src = test_en ? pattern : disc_i;

  ltrig_hitfront #(.NCH(NCH)) u_front (
    .clk(clk), .rst_n(rst_i), .src(src), .lvl(lvl), .pulse(pulse)
  );

  assign live    = pulse & ~block;
  assign hit_ind = |live[NIND-1:0];
  assign hit_col = |live[NCH-1:NIND];

  ltrig_stretch #(.WID_W(WID_W)) u_str_ind (
    .clk(clk), .rst_n(rst_i), .trig(hit_ind), .width(width), .busy(trig_ind_o)
  );
  ltrig_stretch #(.WID_W(WID_W)) u_str_col (
    .clk(clk), .rst_n(rst_i), .trig(hit_col), .width(width), .busy(trig_col_o)
  );

  ltrig_ratemeter #(.NCH(NCH), .GATE_CLKS(GATE_CLKS), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_i), .pulse(pulse), .rate_flat(rate_flat)
  );

  always_comb begin
    mon_d = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (mon_sel == SEL_W'(i)) mon_d = lvl[i];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mon_o <= 1'b0;
    else        mon_o <= mon_d;
  end

  // R9: out-of-range selector keeps the monitor low
  p_mon_off_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (int'(mon_sel) >= NCH) |=> !mon_o);
  // R2: a blocked channel alone never starts a proposal
  p_blocked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (block == '1) |=> !$rose(trig_ind_o) && !$rose(trig_col_o));
endmodule

// File: tb/ltrig_ctrl_test.sv
module ltrig_ctrl_test;
  localparam int NCH = 18;
  localparam int G   = 64;
  localparam int CW  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  din_main = '0;
  logic            tog_fast = 1'b0, tog_slow = 1'b0;
  logic            run_fast = 1'b0, run_slow = 1'b0;
  logic [NCH-1:0]  disc;
  logic [6:0]      addr = '0;
  logic            we = 1'b0;
  logic [NCH-1:0]  wdata = '0;
  logic [31:0]     rdata;
  logic            t_ind, t_col, mon;
  logic [NCH*8-1:0] thr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  assign disc = din_main | (NCH'(tog_fast) << 16) | (NCH'(tog_slow) << 15);

  ltrig_ctrl #(.NCH(NCH), .NIND(9), .GATE_CLKS(G), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .disc_i(disc), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .trig_ind_o(t_ind), .trig_col_o(t_col),
    .mon_o(mon), .thr_o(thr)
  );

  // {block, hits, expected induction, expected collection}
  localparam logic [37:0] VEC [8] = '{
    {18'h00000, 18'h00001, 1'b1, 1'b0},
    {18'h00000, 18'h00100, 1'b1, 1'b0},
    {18'h00000, 18'h00200, 1'b0, 1'b1},
    {18'h00000, 18'h20000, 1'b0, 1'b1},
    {18'h00000, 18'h01008, 1'b1, 1'b1},
    {18'h00001, 18'h00001, 1'b0, 1'b0},
    {18'h001FF, 18'h003FF, 1'b0, 1'b1},
    {18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [NCH-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic lat3;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_len(input bit col, output int n);
    n = 0;
    while ((col ? t_col : t_ind) && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  always @(negedge clk) if (run_fast) tog_fast <= ~tog_fast; else tog_fast <= 1'b0;
  logic ph = 1'b0;
  always @(negedge clk) begin
    ph <= ~ph;
    if (!run_slow) tog_slow <= 1'b0;
    else if (ph) tog_slow <= ~tog_slow;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R11: reset state
    chk("R11 ind", 32'(t_ind), 0);
    chk("R11 col", 32'(t_col), 0);
    chk("R11 mon", 32'(mon), 0);
    chk("R11 thr", 32'(thr[31:0]), 0);
    rd(7'h00, r); chk("R11 block", r, 0);
    rd(7'h03, r); chk("R11 width", r, 1);
    rd(7'h04, r); chk("R11 monsel", r, 0);

    // R1 R2 R3: table of plane patterns
    wr(7'h03, 18'd3);
    for (int v = 0; v < 8; v++) begin
      wr(7'h00, VEC[v][37:20]);
      rd(7'h00, r); chk("R2 readback", r, 32'(VEC[v][37:20]));
      din_main = VEC[v][19:2];
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R3 not early ind", 32'(t_ind), 0);
      chk("R3 not early col", 32'(t_col), 0);
      @(posedge clk); @(negedge clk);
      chk("R1 ind", 32'(t_ind), 32'(VEC[v][1]));
      chk("R1 col", 32'(t_col), 32'(VEC[v][0]));
      idle(12);
      chk("R3 held line one pulse", 32'(t_ind | t_col), 0);
      din_main = '0;
      idle(6);
    end
    wr(7'h00, 18'h0);

    // R4: width 5 and width 0
    wr(7'h03, 18'd5);
    din_main = 18'h00001; lat3;
    high_len(1'b0, n); chk("R4 width 5", 32'(n), 5);
    din_main = '0; idle(6);
    wr(7'h03, 18'd0);
    din_main = 18'h00400; lat3;
    high_len(1'b1, n); chk("R4 width 0 as 1", 32'(n), 1);
    din_main = '0; idle(6);

    // R5: second edge while high is dropped
    wr(7'h03, 18'd6);
    n = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (t_ind) n++;
      if (k == 0) din_main = 18'h00002;
      if (k == 2) din_main = 18'h00000;
      if (k == 4) din_main = 18'h00002;
    end
    chk("R5 no retrigger", 32'(n), 6);
    din_main = '0; idle(6);

    // R8: test mode
    wr(7'h03, 18'd3);
    wr(7'h02, 18'd1);
    din_main = '1; lat3;
    chk("R8 inputs ignored ind", 32'(t_ind), 0);
    chk("R8 inputs ignored col", 32'(t_col), 0);
    wr(7'h01, 18'h00400); lat3;
    chk("R8 pattern col", 32'(t_col), 1);
    chk("R8 pattern ind", 32'(t_ind), 0);
    din_main = '0;
    wr(7'h01, 18'h0); idle(8);
    wr(7'h02, 18'd0); idle(8);

    // R9: monitor
    wr(7'h04, 18'd4);
    din_main = 18'h00010; lat3;
    chk("R9 monitor follows", 32'(mon), 1);
    din_main = '0; lat3;
    chk("R9 monitor falls", 32'(mon), 0);
    wr(7'h04, 18'd17);
    din_main = 18'h20000; lat3;
    chk("R9 monitor ch17", 32'(mon), 1);
    wr(7'h04, 18'd20); idle(2);
    chk("R9 monitor off sel 20", 32'(mon), 0);
    din_main = '0; idle(8);

    // R10: thresholds
    wr(7'h27, 18'hA5);
    chk("R10 thr7 port", 32'(thr[63:56]), 32'hA5);
    wr(7'h31, 18'h3C);
    chk("R10 thr17 port", 32'(thr[143:136]), 32'h3C);
    rd(7'h27, r); chk("R10 thr7 read", r, 32'hA5);

    // R6 R7: rate metering with blocked channels
    wr(7'h00, 18'h18000);
    run_fast = 1'b1; run_slow = 1'b1;
    idle(4 * G);
    chk("R2 blocked toggles quiet", 32'(t_col), 0);
    rd(7'h4F, r); chk("R6 rate ch15", r, 16);
    rd(7'h50, r); chk("R7 rate ch16 saturates", r, 31);
    rd(7'h42, r); chk("R6 rate idle ch2", r, 0);
    run_fast = 1'b0; run_slow = 1'b0;
    idle(3 * G);
    rd(7'h4F, r); chk("R6 rate cleared", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule